// File: doc/BRIEF.md
# Cascaded Coarse/Fine Sample Delay Timebase

This block is the digital timebase of a sampling instrument. A single fast master clock drives all of its logic. A divider derives a slow tick enable from that clock, one cycle in every eight. A programmable repetition counter advances on the slow tick. Each time it runs out, it begins a new measurement cycle.

At that moment a coarse delay counter starts. It counts slow ticks, so one coarse step equals eight master cycles. When the coarse delay runs out, a fine delay counter starts. It counts master cycles, one fine step per cycle. The block gives three outputs:

- a one-cycle driver pulse when the coarse delay begins;
- a sticky interrupt request when the coarse delay ends;
- a one-cycle sampler pulse when the fine delay ends.

A processor writes the period, coarse and fine values through a small register port. These writes go into shadow registers. The shadow values are copied into the counters only when a new repetition period starts. A processor that answers the interrupt by writing new delays therefore changes only the next sample, never the current one.

Top module: `sample_delay_timebase`

## Requirements
- R1: During reset and after reset is released, `drvTrig`, `irqReq` and `sampTrig` stay low until the first repetition period begins.
- R2: The first `drvTrig` pulse appears 8 clock edges after reset is released. Later pulses follow every 8×P cycles. P is the period register at address 0 (all 16 data bits), with a reset value of 875.
- R3: `drvTrig` is high for exactly one cycle at a time.
- R4: `irqReq` rises 8×C cycles after the cycle in which `drvTrig` is high. C is the coarse register at address 1, taken from data bits [11:0].
- R5: `sampTrig` is high 8×C+F cycles after the cycle in which `drvTrig` is high. F is the fine register at address 2, taken from data bits [2:0].
- R6: A zero stage adds no delay. With C=0, `irqReq` rises in the same cycle as `drvTrig`. With C=0 and F=0, `sampTrig` also fires in that cycle.
- R7: Writes to the coarse or fine register affect only periods that start after the write. A write made after the interrupt does not move the pending sampler pulse.
- R8: `irqReq` stays high until a write to address 3 with data bit 0 set. A write to address 3 with bit 0 clear leaves it high. After an acknowledging write, `irqReq` is low from the next cycle.
- R9: `sampTrig` is high for exactly one cycle at a time.
- R10: A write to the period register takes effect at the next reload. The period running when the write is made completes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 period, 1 coarse, 2 fine, 3 acknowledge |
| wrData | input | 16 | Register write data |
| drvTrig | output | 1 | One-cycle pulse at the start of the coarse delay |
| irqReq | output | 1 | Sticky request raised at the end of the coarse delay |
| sampTrig | output | 1 | One-cycle pulse at the end of the fine delay |

## Verification
Every output timing is defined relative to the cycle in which `drvTrig` is high:

- the driver pulse repeats every 8×P cycles;
- the interrupt rises 8×C cycles later;
- the sampler pulse follows 8×C+F cycles later.

The bench numbers cycles from the first edge after reset. From the programmed values it computes the exact cycle number of each event and queues it. The monitor samples the outputs on the falling clock edge and compares each event against the head of its queue by cycle number. A pulse that comes early, comes late, or is not expected is therefore reported, and so is one still pending at the end.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Register addresses on the write port
  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_COARSE = 2'd1;
  localparam logic [1:0] ADDR_FINE   = 2'd2;
  localparam logic [1:0] ADDR_ACK    = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;       // slow-rate enable
    logic expire;     // repetition period ends, new delay begins
    logic coarseEnd;  // coarse stage finished this cycle
  } tbStrobe_t;

  // Flags from datapath to control
  typedef struct packed {
    logic coarseOne;     // coarse counter at its last step
    logic coarseZero;    // shadow coarse value is zero
    logic fineOne;       // fine counter at its last step
    logic fineShZero;    // shadow fine value is zero
    logic fineWorkZero;  // working fine value is zero
    logic ackReq;        // processor acknowledge write
  } tbStatus_t;

endpackage

// File: rtl/tbase_dpath.sv
module tbase_dpath
  import tbase_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PERIOD_W    = 16,
  parameter int COARSE_W    = 12,
  parameter int FINE_W      = 3,
  parameter int PERIOD_INIT = 875
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  tbStrobe_t           strobe,
  output logic [PERIOD_W-1:0] periodVal,
  output tbStatus_t           status
);

  localparam logic [PERIOD_W-1:0] PERIOD_RST = PERIOD_W'(PERIOD_INIT);

  logic [PERIOD_W-1:0] periodSh;
  logic [COARSE_W-1:0] coarseSh;
  logic [FINE_W-1:0]   fineSh;
  logic [FINE_W-1:0]   fineWork;
  logic [COARSE_W-1:0] coarseLeft;
  logic [FINE_W-1:0]   fineLeft;
  logic [FINE_W-1:0]   fineSrc;

  // Shadow registers written by the processor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodSh <= PERIOD_RST;
      coarseSh <= '0;
      fineSh   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PERIOD: periodSh <= wrData[PERIOD_W-1:0];
        ADDR_COARSE: coarseSh <= wrData[COARSE_W-1:0];
        ADDR_FINE:   fineSh   <= wrData[FINE_W-1:0];
        default:     ;
      endcase
    end
  end

  // Working fine value, captured when a period starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              fineWork <= '0;
    else if (strobe.expire) fineWork <= fineSh;
  end

  // A coarse stage of zero ends in the start cycle, before fineWork is loaded
  assign fineSrc = strobe.expire ? fineSh : fineWork;

  // Coarse down-counter, steps on the slow tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 coarseLeft <= '0;
    else if (strobe.expire)                    coarseLeft <= coarseSh;
    else if (strobe.tick && coarseLeft != '0)  coarseLeft <= coarseLeft - 1'b1;
  end

  // Fine down-counter, steps every master cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   fineLeft <= '0;
    else if (strobe.coarseEnd)   fineLeft <= fineSrc;
    else if (fineLeft != '0)     fineLeft <= fineLeft - 1'b1;
  end

  assign periodVal           = periodSh;
  assign status.coarseOne    = (coarseLeft == COARSE_W'(1));
  assign status.coarseZero   = (coarseSh == '0);
  assign status.fineOne      = (fineLeft == FINE_W'(1));
  assign status.fineShZero   = (fineSh == '0);
  assign status.fineWorkZero = (fineWork == '0);
  assign status.ackReq       = wrEn && (wrAddr == ADDR_ACK) && wrData[0];

  // R7: the working fine value changes only when a period starts
  a_r7_fine_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.expire |=> $stable(fineWork));

  // R5: once loaded, the fine counter steps down by one every cycle
  a_r5_fine_step: assert property (@(posedge clk) disable iff (!rstN)
    (fineLeft > FINE_W'(1) && !strobe.coarseEnd) |=> fineLeft == $past(fineLeft) - 1'b1);

endmodule

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
#(
  parameter int DIV      = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] periodVal,
  input  tbStatus_t           status,
  output tbStrobe_t           strobe,
  output logic                drvTrig,
  output logic                irqReq,
  output logic                sampTrig
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0]    divCnt;
  logic [PERIOD_W-1:0] repCnt;
  logic                coarseActive;
  logic                fineActive;
  logic                tick, expire, coarseEnd, fineEnd, fineZero;

  always_comb begin
    tick      = (divCnt == DIV_LAST);
    expire    = tick && (repCnt == '0);
    coarseEnd = expire ? status.coarseZero
                       : (coarseActive && tick && status.coarseOne);
    fineZero  = expire ? status.fineShZero : status.fineWorkZero;
    fineEnd   = coarseEnd ? fineZero : (fineActive && status.fineOne);
  end

  assign strobe = '{tick: tick, expire: expire, coarseEnd: coarseEnd};

  // Slow tick divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                    divCnt <= divCnt + 1'b1;
  end

  // Repetition counter; zero period behaves as one tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) repCnt <= '0;
    else if (tick) begin
      if (repCnt == '0) repCnt <= (periodVal == '0) ? '0 : periodVal - 1'b1;
      else              repCnt <= repCnt - 1'b1;
    end
  end

  // Stage activity flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseActive <= 1'b0;
      fineActive   <= 1'b0;
    end else begin
      if (expire)         coarseActive <= !status.coarseZero;
      else if (coarseEnd) coarseActive <= 1'b0;
      if (coarseEnd)      fineActive   <= !fineZero;
      else if (fineEnd)   fineActive   <= 1'b0;
    end
  end

  // Registered event outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvTrig  <= 1'b0;
      sampTrig <= 1'b0;
      irqReq   <= 1'b0;
    end else begin
      drvTrig  <= expire;
      sampTrig <= fineEnd;
      if (coarseEnd)          irqReq <= 1'b1;
      else if (status.ackReq) irqReq <= 1'b0;
    end
  end

  // R2: a driver pulse always follows a slow tick
  a_r2_drv_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    drvTrig |-> $past(tick));

  // R3: driver pulse is one cycle wide
  a_r3_drv_single: assert property (@(posedge clk) disable iff (!rstN)
    drvTrig |=> !drvTrig);

  // R9: sampler pulse is one cycle wide
  a_r9_samp_single: assert property (@(posedge clk) disable iff (!rstN)
    sampTrig |=> !sampTrig);

  // R4: end of coarse stage raises the request
  a_r4_irq_on_coarse_end: assert property (@(posedge clk) disable iff (!rstN)
    coarseEnd |=> irqReq);

  // R8: request holds until acknowledged
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !status.ackReq) |=> irqReq);

  // R6: zero coarse value raises the request together with the driver pulse
  a_r6_zero_coarse: assert property (@(posedge clk) disable iff (!rstN)
    (expire && status.coarseZero) |=> (irqReq && drvTrig));

endmodule

// File: rtl/sample_delay_timebase.sv
module sample_delay_timebase
  import tbase_pkg::*;
#(
  parameter int DIV         = 8,
  parameter int DATA_W      = 16,
  parameter int PERIOD_W    = 16,
  parameter int COARSE_W    = 12,
  parameter int FINE_W      = 3,
  parameter int PERIOD_INIT = 875
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              drvTrig,
  output logic              irqReq,
  output logic              sampTrig
);

  tbStrobe_t           strobe;
  tbStatus_t           status;
  logic [PERIOD_W-1:0] periodVal;

  tbase_ctrl #(
    .DIV      (DIV),
    .PERIOD_W (PERIOD_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .periodVal (periodVal),
    .status    (status),
    .strobe    (strobe),
    .drvTrig   (drvTrig),
    .irqReq    (irqReq),
    .sampTrig  (sampTrig)
  );

  tbase_dpath #(
    .DATA_W      (DATA_W),
    .PERIOD_W    (PERIOD_W),
    .COARSE_W    (COARSE_W),
    .FINE_W      (FINE_W),
    .PERIOD_INIT (PERIOD_INIT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .periodVal (periodVal),
    .status    (status)
  );

endmodule

// File: tb/sample_delay_timebase_tb_top.sv
module sample_delay_timebase_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        drvTrig, irqReq, sampTrig;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic prevDrv = 1'b0, prevIrq = 1'b0, prevSamp = 1'b0;

  int    drvQ[$], irqQ[$], smpQ[$];
  string drvT[$], irqT[$], smpT[$];

  always #2 clk = ~clk;

  sample_delay_timebase dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .drvTrig(drvTrig), .irqReq(irqReq), .sampTrig(sampTrig)
  );

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver side: queue an expected event (0 drive, 1 request rise, 2 sampler)
  task automatic pushExp(input int kind, input int at, input string tag);
    case (kind)
      0: begin drvQ.push_back(at); drvT.push_back(tag); end
      1: begin irqQ.push_back(at); irqT.push_back(tag); end
      default: begin smpQ.push_back(at); smpT.push_back(tag); end
    endcase
  endtask

  task automatic popCheck(input int kind);
    int    exp;
    string tag;
    bit    have;
    have = 1'b0; exp = -1;
    case (kind)
      0: if (drvQ.size() > 0) begin exp = drvQ.pop_front(); tag = drvT.pop_front(); have = 1'b1; end
      1: if (irqQ.size() > 0) begin exp = irqQ.pop_front(); tag = irqT.pop_front(); have = 1'b1; end
      default: if (smpQ.size() > 0) begin exp = smpQ.pop_front(); tag = smpT.pop_front(); have = 1'b1; end
    endcase
    if (!have) tag = (kind == 0) ? "R2 unexpected drive" : (kind == 1) ? "R4 unexpected request" : "R5 unexpected sampler";
    check(have && exp == cyc, tag, cyc, exp);
  endtask

  // Monitor: compare events by cycle number, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDrv)  check(!drvTrig, "R3 drive width", int'(drvTrig), 0);
      if (prevSamp) check(!sampTrig, "R9 sampler width", int'(sampTrig), 0);
      if (drvTrig)  popCheck(0);
      if (irqReq && !prevIrq) popCheck(1);
      if (sampTrig) popCheck(2);
      prevDrv  <= drvTrig;
      prevIrq  <= irqReq;
      prevSamp <= sampTrig;
    end
  end

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic script();
    // R1: outputs low in reset
    repeat (3) @(negedge clk);
    check(!drvTrig, "R1 drive in reset", int'(drvTrig), 0);
    check(!irqReq, "R1 request in reset", int'(irqReq), 0);
    check(!sampTrig, "R1 sampler in reset", int'(sampTrig), 0);
    // Period 0: default period, zero delays (R6)
    pushExp(0, 8, "R2 first drive");
    pushExp(1, 8, "R6 zero coarse request");
    pushExp(2, 8, "R6 zero delay sampler");
    rstN = 1'b1;
    waitCyc(9);
    writeReg(2'd3, 16'd1);
    writeReg(2'd0, 16'd20);
    writeReg(2'd1, 16'd3);
    writeReg(2'd2, 16'd5);
    // Period 1: old period of 875 completes (R10)
    pushExp(0, 7008, "R10 old period completes");
    pushExp(1, 7032, "R4 coarse 3");
    pushExp(2, 7037, "R5 coarse 3 fine 5");
    waitCyc(7033);
    // R7: writes after the request must not move the pending sampler at 7037
    writeReg(2'd3, 16'd1);
    writeReg(2'd1, 16'd1);
    writeReg(2'd2, 16'd7);
    pushExp(0, 7168, "R2 new period 20");
    pushExp(1, 7176, "R4 coarse 1");
    pushExp(2, 7183, "R7 new delays next period");
    waitCyc(7184);
    writeReg(2'd3, 16'd1);
    writeReg(2'd1, 16'd0);
    writeReg(2'd2, 16'd3);
    pushExp(0, 7328, "R2 period 20");
    pushExp(1, 7328, "R6 zero coarse request");
    pushExp(2, 7331, "R5 coarse 0 fine 3");
    waitCyc(7332);
    writeReg(2'd3, 16'd1);
    writeReg(2'd1, 16'd2);
    writeReg(2'd2, 16'd0);
    pushExp(0, 7488, "R2 period 20");
    pushExp(1, 7504, "R4 coarse 2");
    pushExp(2, 7504, "R6 zero fine sampler");
    // R8: sticky request
    waitCyc(7545);
    check(irqReq, "R8 request held", int'(irqReq), 1);
    writeReg(2'd3, 16'd0);
    check(irqReq, "R8 bit0 clear no ack", int'(irqReq), 1);
    writeReg(2'd3, 16'd1);
    check(!irqReq, "R8 acknowledged", int'(irqReq), 0);
    waitCyc(7560);
    check(drvQ.size() + irqQ.size() + smpQ.size() == 0, "R2 pending events",
          drvQ.size() + irqQ.size() + smpQ.size(), 0);
  endtask

  initial begin
    fork
      script();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule